// File: doc/BRIEF.md
# Reloading System Tick Timer

This block is a 24-bit down-counter that produces a regular time base for an operating system or for bare-metal delay loops. Software programs a reload value and clears the current count. It then enables the timer. The counter steps down to zero and reloads on the following counting clock. Each step from 1 to 0 sets a sticky flag and, if enabled, raises a one-cycle interrupt request. A reload value of N-1 gives an event every N counting clocks.

The counter can advance on every processor clock. It can also advance only on cycles where a slower reference source sends a synchronous one-cycle tick. A control bit selects between the two. Software reaches the timer through a small synchronous register bus of four word registers:

- control/status
- reload
- current value
- a read-only calibration constant

Reading the status clears the flag. Writing the current-value register clears the count and the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status register (offset 0x0) reads 0 and `irq_o` is low.
- R2: When counting, the counter decrements by one per counting clock. On the counting clock after it reads 0 it loads the reload value, so a reload value of N-1 gives a period of N counting clocks.
- R3: Control bit 2 selects the counting clock. With 1, every clock cycle counts. With 0, only cycles with `ref_tick_i` high count.
- R4: The status flag (bit 16 of offset 0x0) is set only when the counter steps from 1 to 0. With a reload value of 0 and the counter at 0, no flag and no interrupt occur.
- R5: A read of the status register (`re_i` high at offset 0x0) clears the flag on that clock edge. A flag set by a wrap on the same edge stays set.
- R6: A write of any data to offset 0x8 sets the counter and the flag to 0 on that edge and raises no interrupt. The counter loads the reload value on the next counting clock.
- R7: `irq_o` is a one-cycle pulse in the cycle after the 1-to-0 step, while the count reads 0. It occurs only when control bit 1 is 1.
- R8: With control bit 0 (enable) at 0, the counter holds its value.
- R9: The register map is as follows:
  - Offset 0x0 holds control bits [2:0] (read/write), the flag in bit 16, and zeros elsewhere.
  - Offset 0x4 holds the reload value in bits [23:0], with upper bits reading 0.
  - Offset 0x8 returns the count in bits [23:0].
  - Offset 0xC returns the `CALIB_VAL` parameter, and writes to it are ignored.
- R10: Writing 0 to the reload register while counting lets the counter run down, raise one final event at the 1-to-0 step, and then stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Synchronous reference tick, one cycle per reference period |
| addr_i | input | 4 | Byte offset of the word register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe; only side effect is clearing the status flag |
| rdata_o | output | 32 | Read data for `addr_i`, valid in the same cycle |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The assertions assume that `ref_tick_i` is already synchronous to `clk_i`. They also assume that bus accesses are whole words whose two low address bits carry no meaning. The stimulus drives every input at the falling edge, so each write, read or tick falls inside exactly one rising edge. It keeps `ref_tick_i` to isolated single-cycle pulses. A write to offset 0x8 is allowed to coincide with a counting cycle, and the clear then takes precedence over the step. The checks treat that clear as overriding any wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CUR    = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  // bit order is the visible control layout: [2]=src, [1]=irq_en, [0]=en
  typedef struct packed {
    logic src;
    logic irq_en;
    logic en;
  } ctrl_t;

  localparam int unsigned FLAG_BIT = 16;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned         CNT_W     = 24,
  parameter int unsigned         DATA_W    = 32,
  parameter logic [DATA_W-1:0]   CALIB_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_wr_o,
  output logic              stat_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  reg_sel_e          sel;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              unused_bits;

  assign sel         = reg_sel_e'(addr_i[3:2]);
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_CTRL)   ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (sel == SEL_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata_o[CTRL_W-1:0] = ctrl_q;
        rdata_o[FLAG_BIT]   = flag_i;
      end
      SEL_RELOAD: rdata_o = DATA_W'(reload_q);
      SEL_CUR:    rdata_o = DATA_W'(cnt_i);
      default:    rdata_o = CALIB_VAL;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign cur_wr_o  = we_i && (sel == SEL_CUR);
  assign stat_rd_o = re_i && (sel == SEL_CTRL);

  // R9
  calib_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_CALIB) |-> (rdata_o == CALIB_VAL));
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_i,
  input  logic             irq_en_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cur_wr_i,
  input  logic             stat_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, irq_q, adv, wrap;

  assign adv  = en_i && (src_i || ref_tick_i);
  // a clearing write overrides the step, so it can never produce an event
  assign wrap = adv && !cur_wr_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cur_wr_i)   cnt_q <= '0;
      else if (adv)   cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;

      if (cur_wr_i)       flag_q <= 1'b0;
      else if (wrap)      flag_q <= 1'b1;
      else if (stat_rd_i) flag_q <= 1'b0;

      irq_q <= wrap && irq_en_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R4
  flag_from_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(cnt_q) == ONE));
  // R6
  cur_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr_i |=> (cnt_q == '0 && !flag_q && !irq_q));
  // R7
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == '0 && flag_q));
  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R8
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cur_wr_i) |=> $stable(cnt_q));
  // R3
  ref_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !src_i && !ref_tick_i && !cur_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned       CNT_W     = 24,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] CALIB_VAL = 32'h4000_2710
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             cur_wr, stat_rd, flag;

  tick_timer_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_VAL)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .re_i,
    .cnt_i(cnt), .flag_i(flag), .ctrl_o(ctrl), .reload_o(reload),
    .cur_wr_o(cur_wr), .stat_rd_o(stat_rd), .rdata_o
  );

  tick_timer_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .src_i(ctrl.src), .irq_en_i(ctrl.irq_en),
    .ref_tick_i, .reload_i(reload), .cur_wr_i(cur_wr), .stat_rd_i(stat_rd),
    .cnt_o(cnt), .flag_o(flag), .irq_o
  );

  // R5
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !cur_wr && !(flag && irq_o)) |=> (!flag || cnt == '0));
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam logic [31:0] CALIB_V = 32'h4000_2710;
  localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  logic        clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic        irq;
  int          n_cmp = 0, n_bad = 0, n_irq;
  int          exp_c;

  always #4 clk = ~clk;

  tick_timer #(.CALIB_VAL(CALIB_V)) i_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  // {write data, address, expected read-back}
  localparam int NV = 7;
  localparam logic [67:0] VEC [NV] = '{
    {32'hFFFF_FFFF, A_REL,  32'h00FF_FFFF},
    {32'h1234_5678, A_CUR,  32'h0000_0000},
    {32'hFFFF_FFFA, A_CTRL, 32'h0000_0002},
    {32'h0000_0000, A_CAL,  CALIB_V},
    {32'h00AB_CDEF, A_REL,  32'h00AB_CDEF},
    {32'h0000_0000, A_CTRL, 32'h0000_0000},
    {32'hFFFF_FFFF, A_CAL,  CALIB_V}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    peek(A_CTRL, v);
    check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 register map table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:32], VEC[i][67:36]);
      peek(VEC[i][35:32], v);
      check("R9 map", v, VEC[i][31:0]);
    end

    // R2 / R7 periodic count with interrupt, reload 4
    wr(A_REL, 4); wr(A_CUR, 0); wr(A_CTRL, 7);
    for (int i = 0; i < 12; i++) begin
      exp_c = (i == 0) ? 0 : 4 - ((i - 1) % 5);
      peek(A_CUR, v);
      check("R2 count", v, exp_c);
      check("R7 irq", {31'b0, irq}, {31'b0, (i > 0 && exp_c == 0)});
      @(negedge clk);
    end

    // R5 sticky flag cleared by status read
    wr(A_CTRL, 0);
    rd(A_CTRL, v);
    check("R5 flag set", v, 32'h0001_0000);
    rd(A_CTRL, v);
    check("R5 flag cleared", v, 0);

    // R8 disabled counter holds
    wr(A_CTRL, 4);
    peek(A_CUR, v);
    exp_c = int'(v);
    repeat (5) @(negedge clk);
    peek(A_CUR, v);
    check("R8 hold", v, exp_c);

    // R5 read in the same cycle as the wrap keeps the flag
    wr(A_CUR, 0); wr(A_CTRL, 5);
    for (int i = 0; i < 20; i++) begin
      peek(A_CUR, v);
      if (v == 1) begin
        re = 1'b1; addr = A_CTRL; #1;
        @(negedge clk);
        re = 1'b0;
        break;
      end
      @(negedge clk);
    end
    peek(A_CTRL, v);
    check("R5 same-cycle flag", v[16], 1);
    wr(A_CTRL, 0); rd(A_CTRL, v);

    // R6 clearing write mid-count
    wr(A_REL, 4); wr(A_CUR, 0); wr(A_CTRL, 7);
    repeat (7) @(negedge clk);
    peek(A_CUR, v);
    check("R6 pre count", v, 3);
    peek(A_CTRL, v);
    check("R6 pre flag", v[16], 1);
    wr(A_CUR, 32'hDEAD_BEEF);
    peek(A_CUR, v);
    check("R6 count zero", v, 0);
    peek(A_CTRL, v);
    check("R6 flag zero", v[16], 0);
    check("R6 no irq", {31'b0, irq}, 0);
    @(negedge clk);
    peek(A_CUR, v);
    check("R6 reload", v, 4);
    check("R6 no irq after", {31'b0, irq}, 0);

    // R7 interrupt disabled: flag still sets, no pulse
    wr(A_CTRL, 5);
    n_irq = 0;
    for (int i = 0; i < 12; i++) begin
      #1 if (irq) n_irq++;
      @(negedge clk);
    end
    check("R7 masked irq", n_irq, 0);
    peek(A_CTRL, v);
    check("R7 masked flag", v[16], 1);

    // R10 reload 0 stops at next wrap, R4 then no events
    wr(A_CTRL, 0); rd(A_CTRL, v);
    wr(A_REL, 3); wr(A_CUR, 0); wr(A_CTRL, 7);
    @(negedge clk);
    wr(A_REL, 0);
    n_irq = 0;
    for (int i = 0; i < 10; i++) begin
      #1 if (irq) n_irq++;
      @(negedge clk);
    end
    check("R10 final event", n_irq, 1);
    peek(A_CUR, v);
    check("R10 stopped", v, 0);
    rd(A_CTRL, v);
    n_irq = 0;
    for (int i = 0; i < 10; i++) begin
      #1 if (irq) n_irq++;
      @(negedge clk);
    end
    check("R4 no irq at reload 0", n_irq, 0);
    peek(A_CTRL, v);
    check("R4 no flag at reload 0", v[16], 0);

    // R3 reference-tick clocking
    wr(A_CTRL, 0); wr(A_REL, 4); wr(A_CUR, 0); wr(A_CTRL, 1);
    exp_c = 0;
    for (int i = 0; i < 18; i++) begin
      peek(A_CUR, v);
      check("R3 ref count", v, exp_c);
      ref_tick = (i % 3 == 0);
      if (ref_tick) exp_c = (exp_c == 0) ? 4 : exp_c - 1;
      @(negedge clk);
    end
    ref_tick = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule